// File: doc/BRIEF.md
# Calibration Interval Timer

This block schedules periodic oscillator calibration. Software or another block writes a 7-bit interval value, in units of a quarter second, and then pulses a start task. The timer counts that many quarter-second units and then raises a timeout event, which tells the system that a calibration run is due. A prescaler turns the core clock into quarter-second ticks. The parameter `TICKS_PER_QUARTER_S` sets how many clock cycles make one tick.

A start task raises the started event and a stop task raises the stopped event. A separate calibrate task raises a done event after a fixed latency of `CAL_LATENCY` cycles. The calibration work itself is not part of this block. Each of the four events is a sticky flag with its own enable bit. The interrupt line is high while any enabled flag is set.

All task inputs are single-cycle pulses sampled on the rising clock edge. Event flag bit positions are: bit 0 started, bit 1 stopped, bit 2 timeout, bit 3 calibration done.

Top module: `cit_timer`

## Requirements
- R1: The 7-bit interval register can be written at any time through `ival_we`/`ival_wdata`. A start edge from idle uses the register value held before that edge. Later writes do not change a timeout that is already pending.
- R2: A start task on an idle timer makes `running` high and sets flag bit 0 (started) after that edge.
- R3: With an interval N ≥ 1, `running` falls and flag bit 2 (timeout) is set exactly N·`TICKS_PER_QUARTER_S` clock edges after the start edge.
- R4: An interval of zero expires one tick after the start, that is `TICKS_PER_QUARTER_S` edges after the start edge.
- R5: A start task while the timer is running sets flag bit 0 again. It does not reload or move the pending timeout.
- R6: A stop task always clears `running`, cancels any pending timeout and sets flag bit 1 (stopped). This holds even when the timer is already idle.
- R7: A stop task wins over an expiry in the same cycle, so no timeout flag is set. A stop task also wins over a start task in the same cycle: the timer stays idle and no started flag is set.
- R8: A calibrate task sets flag bit 3 (done) exactly `CAL_LATENCY` edges later and has no other effect. A calibrate task while one is still pending restarts the delay.
- R9: Flags stay set until a 1 is written to the matching `evt_clr` bit. If a set and a clear of the same flag land in the same cycle, the flag ends up set.
- R10: `irq` is high exactly when some flag is set while its `evt_en` bit is also 1.
- R11: After reset, all flags are 0 and both `running` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block synchronizes its release |
| ival_we | input | 1 | Write strobe for the interval register |
| ival_wdata | input | INTERVAL_W | New interval value, in quarter-second units |
| task_start | input | 1 | Start task pulse |
| task_stop | input | 1 | Stop task pulse |
| task_cal | input | 1 | Calibrate task pulse |
| evt_clr | input | 4 | Per-flag clear strobes |
| evt_en | input | 4 | Per-flag interrupt enables |
| evt_flags | output | 4 | Sticky event flags |
| running | output | 1 | High while the countdown is active |
| irq | output | 1 | Interrupt request |

## Verification
A wrong countdown or prescaler value does not show at the ports right away. It shows only at the expiry edge, where the timeout flag and the fall of `running` come early or late by whole ticks. The bench therefore keeps an absolute deadline cycle for each start and compares every cycle. A restart that wrongly reloads the count, or a stop that loses against an expiry, changes which edge sets flag bit 2. That difference shows up within one interval. Faults in the calibration delay appear `CAL_LATENCY` cycles after the task as a done flag in the wrong cycle.

// File: rtl/cit_pkg.sv
package cit_pkg;
  localparam int EVT_N = 4;
  typedef enum int {
    EV_STARTED = 0,
    EV_STOPPED = 1,
    EV_TIMEOUT = 2,
    EV_DONE    = 3
  } evt_idx_e;
  typedef enum logic {
    CD_IDLE = 1'b0,
    CD_RUN  = 1'b1
  } cd_state_e;
endpackage

// File: rtl/cit_prescaler.sv
module cit_prescaler #(
  parameter int TICKS = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic count_en,
  output logic tick
);
  localparam int W = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [W-1:0] LAST = W'(TICKS - 1);

  logic [W-1:0] cnt_q, cnt_d;
  logic         cnt_ce;

  always_comb begin
    tick   = count_en && (cnt_q == LAST);
    cnt_ce = restart || count_en;
    if (restart || tick) cnt_d = '0;
    else                 cnt_d = cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end
endmodule

// File: rtl/cit_countdown.sv
module cit_countdown
  import cit_pkg::*;
#(
  parameter int IW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          stop,
  input  logic          tick,
  input  logic [IW-1:0] load_val,
  output logic          running,
  output logic          load_pulse,
  output logic          started_evt,
  output logic          stopped_evt,
  output logic          expire_evt
);
  cd_state_e     st_q, st_d;
  logic [IW-1:0] cnt_q, cnt_d;
  logic          cnt_ce;

  always_comb begin
    st_d        = st_q;
    cnt_d       = cnt_q;
    cnt_ce      = 1'b0;
    load_pulse  = 1'b0;
    started_evt = start && !stop;
    stopped_evt = stop;
    expire_evt  = 1'b0;
    if (stop) begin
      st_d = CD_IDLE;
    end else if (st_q == CD_RUN && tick && cnt_q <= IW'(1)) begin
      expire_evt = 1'b1;
      st_d       = CD_IDLE;
    end else if (start && st_q == CD_IDLE) begin
      st_d       = CD_RUN;
      cnt_d      = load_val;
      cnt_ce     = 1'b1;
      load_pulse = 1'b1;
    end else if (st_q == CD_RUN && tick) begin
      cnt_d  = cnt_q - IW'(1);
      cnt_ce = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= CD_IDLE;
    else        st_q <= st_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_ce) cnt_q <= cnt_d;
  end

  assign running = (st_q == CD_RUN);
endmodule

// File: rtl/cit_cal_delay.sv
module cit_cal_delay #(
  parameter int LAT = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig,
  output logic done_evt
);
  localparam int W = $clog2(LAT + 1);
  localparam logic [W-1:0] LOADV = W'(LAT);

  logic [W-1:0] dly_q, dly_d;
  logic         dly_ce;

  always_comb begin
    done_evt = 1'b0;
    dly_d    = dly_q;
    dly_ce   = 1'b0;
    if (trig) begin
      dly_d  = LOADV;
      dly_ce = 1'b1;
    end else if (dly_q != '0) begin
      dly_ce   = 1'b1;
      dly_d    = dly_q - W'(1);
      done_evt = (dly_q == W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      dly_q <= '0;
    else if (dly_ce) dly_q <= dly_d;
  end
endmodule

// File: rtl/cit_event_bank.sv
module cit_event_bank #(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flags,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_flag
    logic fl_q, fl_d, fl_ce;
    always_comb begin
      fl_ce = set[i] || clr[i];
      fl_d  = set[i];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     fl_q <= 1'b0;
      else if (fl_ce) fl_q <= fl_d;
    end
    assign flags[i] = fl_q;
  end

  assign irq = |(flags & en);
endmodule

// File: rtl/cit_timer.sv
module cit_timer
  import cit_pkg::*;
#(
  parameter int TICKS_PER_QUARTER_S = 8,
  parameter int INTERVAL_W          = 7,
  parameter int CAL_LATENCY         = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ival_we,
  input  logic [INTERVAL_W-1:0] ival_wdata,
  input  logic                  task_start,
  input  logic                  task_stop,
  input  logic                  task_cal,
  input  logic [EVT_N-1:0]      evt_clr,
  input  logic [EVT_N-1:0]      evt_en,
  output logic [EVT_N-1:0]      evt_flags,
  output logic                  running,
  output logic                  irq
);
  logic [1:0]            rst_sync_q;
  logic                  rst_core_n;
  logic [INTERVAL_W-1:0] ival_q;
  logic                  tick, load_pulse;
  logic                  started_evt, stopped_evt, expire_evt, done_evt;
  logic [EVT_N-1:0]      evt_set;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n)  ival_q <= '0;
    else if (ival_we) ival_q <= ival_wdata;
  end

  cit_prescaler #(.TICKS(TICKS_PER_QUARTER_S)) u_presc (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .restart  (load_pulse),
    .count_en (running),
    .tick     (tick)
  );

  cit_countdown #(.IW(INTERVAL_W)) u_cd (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .start       (task_start),
    .stop        (task_stop),
    .tick        (tick),
    .load_val    (ival_q),
    .running     (running),
    .load_pulse  (load_pulse),
    .started_evt (started_evt),
    .stopped_evt (stopped_evt),
    .expire_evt  (expire_evt)
  );

  cit_cal_delay #(.LAT(CAL_LATENCY)) u_cal (
    .clk      (clk),
    .rst_n    (rst_core_n),
    .trig     (task_cal),
    .done_evt (done_evt)
  );

  always_comb begin
    evt_set             = '0;
    evt_set[EV_STARTED] = started_evt;
    evt_set[EV_STOPPED] = stopped_evt;
    evt_set[EV_TIMEOUT] = expire_evt;
    evt_set[EV_DONE]    = done_evt;
  end

  cit_event_bank #(.N(EVT_N)) u_evt (
    .clk   (clk),
    .rst_n (rst_core_n),
    .set   (evt_set),
    .clr   (evt_clr),
    .en    (evt_en),
    .flags (evt_flags),
    .irq   (irq)
  );
endmodule

// File: rtl/cit_timer_chk.sv
module cit_timer_chk (
  input logic       clk,
  input logic       rst_cn,
  input logic       task_start,
  input logic       task_stop,
  input logic [3:0] evt_flags,
  input logic       running,
  input logic       irq
);
  AST_START_FLAGS: assert property (@(posedge clk) disable iff (!rst_cn)
    (task_start && !task_stop) |=> evt_flags[0]);                         // R2
  AST_STOP_IDLES: assert property (@(posedge clk) disable iff (!rst_cn)
    task_stop |=> (evt_flags[1] && !running));                             // R6
  AST_STOP_BEATS_EXPIRY: assert property (@(posedge clk) disable iff (!rst_cn)
    task_stop |=> !$rose(evt_flags[2]));                                   // R7
  AST_FALL_MEANS_TIMEOUT: assert property (@(posedge clk) disable iff (!rst_cn)
    ($fell(running) && !$past(task_stop)) |-> evt_flags[2]);               // R3
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_cn)
    irq |-> (evt_flags != 4'b0000));                                       // R10
endmodule

bind cit_timer cit_timer_chk u_chk (
  .clk        (clk),
  .rst_cn     (rst_core_n),
  .task_start (task_start),
  .task_stop  (task_stop),
  .evt_flags  (evt_flags),
  .running    (running),
  .irq        (irq)
);

// File: tb/cit_timer_bench.sv
module cit_timer_bench;
  localparam int TPQ = 8;
  localparam int LAT = 4;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       ival_we, task_start, task_stop, task_cal;
  logic [6:0] ival_wdata;
  logic [3:0] evt_clr, evt_en, evt_flags;
  logic       running, irq;

  always #2 clk = ~clk;

  cit_timer #(.TICKS_PER_QUARTER_S(TPQ), .INTERVAL_W(7), .CAL_LATENCY(LAT)) u_cit_timer (
    .clk(clk), .rst_n(rst_n), .ival_we(ival_we), .ival_wdata(ival_wdata),
    .task_start(task_start), .task_stop(task_stop), .task_cal(task_cal),
    .evt_clr(evt_clr), .evt_en(evt_en), .evt_flags(evt_flags),
    .running(running), .irq(irq)
  );

  int checks = 0, fails = 0;
  bit finished = 0;
  int cyc, m_deadline, m_cal_dl;
  bit m_run, m_cal_pend;
  logic [6:0] m_ival;
  logic [3:0] m_flags;

  function automatic int expiry_cycle(int start_cyc, int ival);
    return start_cyc + ((ival == 0) ? 1 : ival) * TPQ;
  endfunction

  function automatic logic exp_irq(logic [3:0] f, logic [3:0] e);
    return |(f & e);
  endfunction

  task automatic check(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)", tag, what, act, exp, cyc);
    end
  endtask

  task automatic step(input logic s, input logic p, input logic c, input logic we,
                      input logic [6:0] wd, input logic [3:0] clr, input string tag);
    logic [3:0] set;
    bit was_run;
    task_start = s; task_stop = p; task_cal = c;
    ival_we = we; ival_wdata = wd; evt_clr = clr;
    @(posedge clk);
    cyc++;
    set = '0;
    was_run = m_run;
    if (p) begin
      m_run = 0; set[1] = 1;
    end else begin
      if (m_run && cyc == m_deadline) begin
        m_run = 0; set[2] = 1;
      end
      if (s) begin
        set[0] = 1;
        if (!was_run) begin
          m_run = 1;
          m_deadline = expiry_cycle(cyc, int'(m_ival));
        end
      end
    end
    if (c) begin
      m_cal_pend = 1; m_cal_dl = cyc + LAT;
    end else if (m_cal_pend && cyc == m_cal_dl) begin
      m_cal_pend = 0; set[3] = 1;
    end
    if (we) m_ival = wd;
    m_flags = (m_flags & ~clr) | set;
    @(negedge clk);
    check(tag, "evt_flags", int'(evt_flags), int'(m_flags));
    check(tag, "running", int'(running), int'(m_run));
    check(tag, "irq", int'(irq), int'(exp_irq(m_flags, evt_en)));
  endtask

  task automatic idle(int n, string tag);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 7'd0, 4'h0, tag);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240517));
    rst_n = 0; ival_we = 0; ival_wdata = 0; task_start = 0; task_stop = 0;
    task_cal = 0; evt_clr = 0; evt_en = 4'hF;
    cyc = 0; m_run = 0; m_cal_pend = 0; m_ival = 0; m_flags = 0;
    m_deadline = 0; m_cal_dl = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (3) @(negedge clk);
    // R11 reset state
    check("R11", "evt_flags", int'(evt_flags), 0);
    check("R11", "running", int'(running), 0);
    check("R11", "irq", int'(irq), 0);

    // R1 / R2 / R3: interval 3, rewrite while running has no effect
    step(0, 0, 0, 1, 7'd3, 4'h0, "R1");
    step(1, 0, 0, 0, 7'd0, 4'h0, "R2");
    idle(5, "R3");
    step(0, 0, 0, 1, 7'd9, 4'h0, "R1");
    idle(24, "R3");
    step(0, 0, 0, 0, 7'd0, 4'hF, "R9");
    // R1: new value used at the next start (9 units)
    step(1, 0, 0, 1, 7'd2, 4'h0, "R1");
    idle(75, "R1");
    step(0, 0, 0, 0, 7'd0, 4'hF, "R9");
    // R4: interval zero
    step(0, 0, 0, 1, 7'd0, 4'h0, "R4");
    step(1, 0, 0, 0, 7'd0, 4'h0, "R4");
    idle(12, "R4");
    // R5: restart while running
    step(0, 0, 0, 1, 7'd4, 4'hF, "R5");
    step(1, 0, 0, 0, 7'd0, 4'h0, "R5");
    idle(10, "R5");
    step(0, 0, 0, 0, 7'd0, 4'h1, "R5");
    step(1, 0, 0, 0, 7'd0, 4'h0, "R5");
    idle(30, "R5");
    // R6: stop while idle and while running
    step(0, 1, 0, 0, 7'd0, 4'hF, "R6");
    step(0, 0, 0, 0, 7'd0, 4'hF, "R6");
    step(0, 1, 0, 0, 7'd0, 4'h0, "R6");
    step(1, 0, 0, 0, 7'd0, 4'h0, "R6");
    idle(5, "R6");
    step(0, 1, 0, 0, 7'd0, 4'h0, "R6");
    idle(40, "R6");
    // R7: stop on the expiry edge (interval 2 -> expiry 16 edges after start)
    step(0, 0, 0, 1, 7'd2, 4'hF, "R7");
    step(1, 0, 0, 0, 7'd0, 4'h0, "R7");
    idle(15, "R7");
    step(0, 1, 0, 0, 7'd0, 4'h0, "R7");
    idle(5, "R7");
    step(0, 0, 0, 0, 7'd0, 4'hF, "R7");
    step(1, 1, 0, 0, 7'd0, 4'h0, "R7");
    idle(20, "R7");
    // R8: calibration delay and retrigger
    step(0, 0, 1, 0, 7'd0, 4'hF, "R8");
    idle(2, "R8");
    step(0, 0, 1, 0, 7'd0, 4'h0, "R8");
    idle(6, "R8");
    // R9: clear on the same edge as done is set
    step(0, 0, 1, 0, 7'd0, 4'hF, "R9");
    idle(LAT - 1, "R9");
    step(0, 0, 0, 0, 7'd0, 4'hF, "R9");
    idle(2, "R9");
    // R10: enable masking
    evt_en = 4'b0100;
    step(0, 0, 0, 0, 7'd0, 4'hF, "R10");
    step(1, 0, 0, 0, 7'd0, 4'h0, "R10");
    idle(3, "R10");
    step(0, 1, 0, 0, 7'd0, 4'h0, "R10");
    evt_en = 4'b0011;
    idle(3, "R10");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      logic s, p, c, we;
      logic [6:0] wd;
      logic [3:0] clr;
      s  = ($urandom % 16) == 0;
      p  = ($urandom % 45) == 0;
      c  = ($urandom % 20) == 0;
      we = ($urandom % 10) == 0;
      wd = 7'($urandom % 6);
      clr = (($urandom % 8) == 0) ? 4'($urandom) : 4'h0;
      if (($urandom % 50) == 0) evt_en = 4'($urandom);
      step(s, p, c, we, wd, clr, "RND");
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule